// File: doc/BRIEF.md
# Serial Field-Memory Write Port

This block is the write side of a sequential-access field memory. Bytes arrive on a single write clock, at consecutive addresses from a write pointer. They are gathered eight at a time in a serial staging register. A full staging register is moved into a behavioural storage array in one write. A write reset moves a partly filled staging register into the array and returns the pointer to zero, so a new pass over the memory can start.

The write path runs one clock behind the input pins. Data, write enable and input enable pass through one register stage before they reach the staging register. This lets a second device be chained without glue logic. Write enable acts as the valid qualifier of the byte stream. The port has no ready output and never applies back-pressure: every edge with write enable high takes a byte. Input enable only decides whether that byte is committed to the array. Two sticky flags report breaches of the usage rules. The first is reset pulses placed too close together. The second is a pass with too few active cycles before the next reset. A tap port reads the array without any timing, so its contents can be observed.

Top module: `fm_write_port`

## Requirements
- R1: The active-low asynchronous reset `rst_n` clears the write pointer and both flags.
- R2: A write reset event is a rising edge of the clock on which `wr_rst` is high after being low on the previous edge. On every edge with `wr_rst` high, the pointer becomes 0. On those edges `wr_en`, `in_en` and `din` are ignored, so no byte is taken and the pointer does not advance. A reset held high for several cycles counts as one event.
- R3: On an edge with `wr_rst` low and `wr_en` high, the byte on `din` is taken and the pointer advances by one. The pointer wraps from DEPTH-1 to 0.
- R4: On an edge with `wr_rst` low and `wr_en` low, the pointer holds and nothing is taken. There is no limit on how long `wr_en` may stay low.
- R5: A byte taken while `in_en` is low still uses its address and advances the pointer. Its array location keeps its old content.
- R6: Bytes are committed in aligned blocks of 8 addresses. The block holding addresses 8k..8k+7 is written into the array on the edge after the edge that took its eighth byte. That is one edge later than the input.
- R7: Bytes of a partly filled block are not visible in the array until the next write reset event. They are written on the edge after the event edge. Unfilled positions in that block keep their old content.
- R8: `spacing_err` is set, and stays set until `rst_n`, when a write reset event occurs after fewer than 2 edges with `wr_rst` low since the previous event.
- R9: `short_pass` is set, and stays set until `rst_n`, when a write reset event occurs after fewer than MIN_PASS active edges since the previous event. An active edge has `wr_rst` low and `wr_en` high. The first event after `rst_n` is exempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge active |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_rst | input | 1 | Write reset request, sampled on the clock |
| wr_en | input | 1 | Write enable; byte-valid qualifier and pointer advance |
| in_en | input | 1 | Commit enable for the byte taken on the same edge |
| din | input | 8 | Input byte |
| rd_addr | input | 16 | Array tap address |
| rd_data | output | 8 | Array content at `rd_addr` (0 when out of range) |
| wr_ptr | output | 16 | Current write pointer |
| spacing_err | output | 1 | Sticky flag for reset pulses spaced too closely |
| short_pass | output | 1 | Sticky flag for a pass shorter than MIN_PASS |

## Verification
The bench builds the block with DEPTH = 32 and MIN_PASS = 12. With these values one pass walks the whole pointer range and wraps to zero in a few dozen cycles. The short-pass limit can then be tested at both sides of its boundary: 11 active edges set the flag and 12 do not. The small depth also means a whole pass of known bytes covers the array. Later passes can therefore prove that masked bytes, unfilled block positions and bytes still in the pipeline leave the old content in place.

// File: rtl/fm_wr_pkg.sv
package fm_wr_pkg;
  localparam int PTR_W  = 16;
  localparam int DATA_W = 8;
  localparam int LANES  = 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int BLK_W  = PTR_W - LANE_W;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [PTR_W-1:0]  ptr_t;

  typedef struct packed {
    logic  vld;
    logic  keep;
    logic  flush;
    data_t dat;
    ptr_t  addr;
  } pipe_t;
endpackage

// File: rtl/fm_wr_ctrl.sv
module fm_wr_ctrl
  import fm_wr_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int MIN_PASS = 80,
  parameter int RST_GAP  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_rst,
  input  logic wr_en,
  output ptr_t wr_ptr,
  output logic rst_evt,
  output logic spacing_err,
  output logic short_pass
);
  localparam int GAP_W = $clog2(RST_GAP + 1);
  localparam int ACT_W = $clog2(MIN_PASS + 1);
  localparam ptr_t LAST = PTR_W'(DEPTH - 1);

  logic             rst_q;
  logic             seen_evt;
  logic [GAP_W-1:0] gap_cnt;
  logic [ACT_W-1:0] act_cnt;

  assign rst_evt = wr_rst & ~rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
    end else if (wr_rst) begin
      wr_ptr <= '0;
    end else if (wr_en) begin
      wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q   <= 1'b0;
      gap_cnt <= GAP_W'(RST_GAP);
    end else begin
      rst_q <= wr_rst;
      if (wr_rst)
        gap_cnt <= '0;
      else if (gap_cnt != GAP_W'(RST_GAP))
        gap_cnt <= gap_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cnt <= '0;
    end else if (rst_evt) begin
      act_cnt <= '0;
    end else if (!wr_rst && wr_en && act_cnt != ACT_W'(MIN_PASS)) begin
      act_cnt <= act_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_evt    <= 1'b0;
      spacing_err <= 1'b0;
      short_pass  <= 1'b0;
    end else if (rst_evt) begin
      seen_evt <= 1'b1;
      if (gap_cnt < GAP_W'(RST_GAP))
        spacing_err <= 1'b1;
      if (seen_evt && act_cnt < ACT_W'(MIN_PASS))
        short_pass <= 1'b1;
    end
  end

  assert_ptr_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> wr_ptr == '0);
  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_rst && !wr_en) |=> $stable(wr_ptr));
  assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= LAST);
  assert_spacing_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spacing_err |=> spacing_err);
  assert_short_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    short_pass |=> short_pass);
endmodule

// File: rtl/fm_wr_pipe.sv
module fm_wr_pipe
  import fm_wr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_rst,
  input  logic  rst_evt,
  input  logic  wr_en,
  input  logic  in_en,
  input  data_t din,
  input  ptr_t  wr_ptr,
  output pipe_t pq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pq <= '0;
    end else begin
      pq.vld   <= wr_en & ~wr_rst;
      pq.keep  <= in_en;
      pq.flush <= rst_evt;
      pq.dat   <= din;
      pq.addr  <= wr_ptr;
    end
  end

  assert_no_take_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> !pq.vld);
  assert_flush_follows_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pq.flush |-> $past(wr_rst));
endmodule

// File: rtl/fm_wr_stage.sv
module fm_wr_stage
  import fm_wr_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic  clk,
  input  logic  rst_n,
  input  pipe_t pq,
  input  ptr_t  rd_addr,
  output data_t rd_data
);
  localparam int AW = $clog2(DEPTH);

  data_t              mem [DEPTH];
  data_t              stg_data [LANES];
  logic [LANES-1:0]   stg_mask;
  logic [BLK_W-1:0]   stg_base;

  logic [LANE_W-1:0]  lane;
  logic [BLK_W-1:0]   blk;
  logic               blk_full;
  logic               wr_go;
  logic [BLK_W-1:0]   w_base;
  data_t              w_data [LANES];
  logic [LANES-1:0]   w_mask;

  assign lane     = pq.addr[LANE_W-1:0];
  assign blk      = pq.addr[PTR_W-1:LANE_W];
  assign blk_full = pq.vld && (lane == LANE_W'(LANES - 1));
  assign wr_go    = blk_full || pq.flush;
  assign w_base   = pq.vld ? blk : stg_base;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit       = pq.vld && (lane == LANE_W'(g));
    assign w_data[g] = hit ? pq.dat  : stg_data[g];
    assign w_mask[g] = hit ? pq.keep : stg_mask[g];

    always_ff @(posedge clk) begin
      if (hit) stg_data[g] <= pq.dat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_mask <= '0;
      stg_base <= '0;
    end else if (wr_go) begin
      stg_mask <= '0;
    end else if (pq.vld) begin
      stg_mask <= w_mask;
      stg_base <= blk;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) begin
      for (int i = 0; i < LANES; i++) begin
        if (w_mask[i]) mem[AW'({w_base, LANE_W'(i)})] <= w_data[i];
      end
    end
  end

  assign rd_data = (rd_addr < PTR_W'(DEPTH)) ? mem[AW'(rd_addr)] : '0;

  initial begin
    assert_depth_whole_blocks_R6: assert (DEPTH % LANES == 0 && DEPTH <= 65536);
  end

  assert_flush_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pq.flush |-> !pq.vld);
  assert_same_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pq.vld && stg_mask != '0) |-> stg_base == blk);
  assert_mask_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> stg_mask == '0);
endmodule

// File: rtl/fm_write_port.sv
module fm_write_port
  import fm_wr_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int MIN_PASS = 80,
  parameter int RST_GAP  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_rst,
  input  logic        wr_en,
  input  logic        in_en,
  input  logic [7:0]  din,
  input  logic [15:0] rd_addr,
  output logic [7:0]  rd_data,
  output logic [15:0] wr_ptr,
  output logic        spacing_err,
  output logic        short_pass
);
  logic  rst_evt;
  pipe_t pq;

  fm_wr_ctrl #(
    .DEPTH(DEPTH), .MIN_PASS(MIN_PASS), .RST_GAP(RST_GAP)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_rst(wr_rst), .wr_en(wr_en),
    .wr_ptr(wr_ptr), .rst_evt(rst_evt),
    .spacing_err(spacing_err), .short_pass(short_pass)
  );

  fm_wr_pipe u_pipe (
    .clk(clk), .rst_n(rst_n), .wr_rst(wr_rst), .rst_evt(rst_evt),
    .wr_en(wr_en), .in_en(in_en), .din(din), .wr_ptr(wr_ptr), .pq(pq)
  );

  fm_wr_stage #(.DEPTH(DEPTH)) u_stage (
    .clk(clk), .rst_n(rst_n), .pq(pq), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/fm_write_port_tb.sv
`timescale 1ns/1ps
module fm_write_port_tb;
  localparam int DEPTH    = 32;
  localparam int MIN_PASS = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic        in_en = 1'b0;
  logic [7:0]  din = '0;
  logic [15:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic [15:0] wr_ptr;
  logic        spacing_err;
  logic        short_pass;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fm_write_port #(.DEPTH(DEPTH), .MIN_PASS(MIN_PASS)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_rst(wr_rst), .wr_en(wr_en), .in_en(in_en),
    .din(din), .rd_addr(rd_addr), .rd_data(rd_data), .wr_ptr(wr_ptr),
    .spacing_err(spacing_err), .short_pass(short_pass)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_mem(string req, int addr, int exp);
    rd_addr = 16'(addr);
    #1;
    check(req, int'(rd_data), exp);
  endtask

  task automatic step_idle();
    @(negedge clk);
    wr_rst = 1'b0; wr_en = 1'b0; in_en = 1'b0;
  endtask

  task automatic write_byte(logic [7:0] d, logic ie);
    @(negedge clk);
    wr_rst = 1'b0; wr_en = 1'b1; in_en = ie; din = d;
  endtask

  task automatic rst_on();
    @(negedge clk);
    wr_rst = 1'b1; wr_en = 1'b0; in_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_rst = 1'b0; wr_en = 1'b0; in_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step_idle();
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 ptr", int'(wr_ptr), 0);
    check("R1 spacing_err", int'(spacing_err), 0);
    check("R1 short_pass", int'(short_pass), 0);
  endtask

  task automatic t_fill_wrap();
    rst_on();
    for (int i = 0; i < DEPTH; i++) write_byte(8'(8'hA0 + i), 1'b1);
    step_idle();
    check("R3 wrap ptr", int'(wr_ptr), 0);
    step_idle();
    for (int i = 0; i < DEPTH; i++) check_mem("R6 full pass", i, 8'hA0 + i);
    check("R9 no short after long pass", int'(short_pass), 0);
  endtask

  task automatic t_block_delay();
    rst_on();
    for (int i = 0; i < 8; i++) write_byte(8'(8'hC0 + i), 1'b1);
    step_idle();
    check_mem("R6 not yet committed", 7, 8'hA7);
    step_idle();
    check_mem("R6 committed one edge later", 7, 8'hC7);
    check_mem("R6 block start", 0, 8'hC0);
  endtask

  task automatic t_partial_and_mask();
    for (int i = 0; i < 3; i++) write_byte(8'(8'hD0 + i), 1'b1);
    for (int i = 0; i < 3; i++) begin
      step_idle();
      din = 8'(8'hF0 + i);
    end
    check("R4 ptr held", int'(wr_ptr), 11);
    check_mem("R7 partial held back", 8, 8'hA8);
    write_byte(8'hEE, 1'b0);
    step_idle();
    check("R5 ptr advances with in_en low", int'(wr_ptr), 12);
    rst_on();
    step_idle();
    check("R2 ptr zero after reset", int'(wr_ptr), 0);
    check_mem("R7 not before flush edge", 8, 8'hA8);
    step_idle();
    check_mem("R7 flushed 8", 8, 8'hD0);
    check_mem("R7 flushed 10", 10, 8'hD2);
    check_mem("R5 masked byte keeps old", 11, 8'hAB);
    check_mem("R7 unfilled lane keeps old", 12, 8'hAC);
    check("R9 exactly MIN_PASS no flag", int'(short_pass), 0);
    check("R8 wide spacing no flag", int'(spacing_err), 0);
  endtask

  task automatic t_reset_ignores_we();
    @(negedge clk);
    wr_rst = 1'b1; wr_en = 1'b1; in_en = 1'b1; din = 8'h55;
    @(negedge clk);
    step_idle();
    check("R2 held reset no advance", int'(wr_ptr), 0);
    check("R9 empty pass flagged", int'(short_pass), 1);
    check("R2 held reset one event", int'(spacing_err), 0);
    write_byte(8'h77, 1'b1);
    step_idle();
    check("R2 first byte at address 0", int'(wr_ptr), 1);
    repeat (3) step_idle();
    check("R9 flag sticky", int'(short_pass), 1);
  endtask

  task automatic t_spacing_bad();
    do_reset();
    check("R1 flags cleared", int'(short_pass) + int'(spacing_err), 0);
    rst_on();
    step_idle();
    rst_on();
    step_idle();
    check("R8 one low cycle flagged", int'(spacing_err), 1);
    step_idle();
    check("R8 flag sticky", int'(spacing_err), 1);
  endtask

  task automatic t_pass_boundary();
    do_reset();
    rst_on();
    for (int i = 0; i < MIN_PASS; i++) write_byte(8'(i), 1'b1);
    rst_on();
    step_idle();
    check("R9 MIN_PASS edges ok", int'(short_pass), 0);
    check("R8 spacing ok", int'(spacing_err), 0);
    for (int i = 0; i < MIN_PASS - 1; i++) write_byte(8'(i), 1'b1);
    rst_on();
    step_idle();
    check("R9 one short flagged", int'(short_pass), 1);
    check("R8 still clear", int'(spacing_err), 0);
  endtask

  initial begin
    t_reset_state();
    t_fill_wrap();
    t_block_delay();
    t_partial_and_mask();
    t_reset_ignores_we();
    t_spacing_bad();
    t_pass_boundary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule